// File: doc/BRIEF.md
# Price-Level Order Book Builder

This block keeps an aggregated order book for one configured instrument. The book holds a bid side and an ask side, and each side is a list of price levels, each level carrying its total resting size. The block receives a stream of already-decoded order-log updates over a valid/ready handshake. Every update names an action, a side, an instrument, a price, a size and a timestamp. Updates for any instrument other than the configured one are accepted and thrown away. Matching updates are applied to the sorted level list of their side.

After each applied update the block compares the visible top of the book (the best `TOP` levels of both sides) with its state before the update. It raises a one-cycle snapshot strobe only when that top actually changed. The snapshot shows the best levels of both sides as price/size pairs: bids are ordered from highest price down, asks from lowest price up, and the two sides are paired by index. It also carries the instrument identifier and the timestamp of the update that caused it. A downstream strategy can therefore react to each real top-of-book change exactly once and can line it up with other feeds by time.

Top module: `priceLevelBook`

## Requirements
- R1: After reset both sides are empty, every snapshot slot reads price 0 and size 0, `snapValid` is 0 and `updReady` is 1.
- R2: Side code 0 is bid and 1 is ask. A level at a new price is inserted in order. Bid slot 0 holds the highest bid price, ask slot 0 holds the lowest ask price, and no two levels on one side share a price.
- R3: Action code 0 (add) adds the update size to the level at that price. If no level exists at that price, it creates one with the update size. An add of size 0 at an absent price creates nothing.
- R4: Action code 1 (set) replaces the size of the level at that price. A set to size 0 removes the level. A set at an absent price with nonzero size creates the level.
- R5: Action code 2 (subtract) lowers the level's size. The level is removed when the subtracted amount is at least its size. A subtract at an absent price changes nothing.
- R6: `snapValid` pulses for exactly one cycle, in the second cycle after the accepting clock edge, only if the best `TOP` levels of either side differ from before the update. No pulse follows an update that leaves them unchanged, including a change deeper than `TOP`.
- R7: While `snapValid` is high, `snapTime` and `snapInst` show the timestamp and instrument of the update that caused the snapshot.
- R8: An update whose instrument differs from `cfgInst` is accepted with `updReady` staying high, produces no snapshot and leaves the book unchanged.
- R9: After a matching update is accepted, `updReady` is low for the next two cycles and then returns high.
- R10: Each side holds at most `DEPTH` levels. When a side is full, a new price worse than every held level is dropped, and a better one pushes out the worst level. Slots beyond the held levels read price 0 and size 0.
- R11: Action code 3 has no effect on the book and produces no snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgInst | input | IW | Instrument identifier the book follows |
| updValid | input | 1 | Update offered |
| updReady | output | 1 | Block can take an update |
| updAction | input | 2 | 0 add, 1 set, 2 subtract, 3 none |
| updSide | input | 1 | 0 bid, 1 ask |
| updInst | input | IW | Instrument of the update |
| updPrice | input | PW | Level price |
| updSize | input | SW | Size operand |
| updTime | input | TW | Timestamp of the update |
| snapValid | output | 1 | One-cycle snapshot strobe |
| snapInst | output | IW | Instrument of the snapshot |
| snapTime | output | TW | Timestamp of the causing update |
| snapBidPrice | output | TOP*PW | Bid prices, slot k at bits k*PW upward |
| snapBidSize | output | TOP*SW | Bid sizes, slot k at bits k*SW upward |
| snapAskPrice | output | TOP*PW | Ask prices, slot k at bits k*PW upward |
| snapAskSize | output | TOP*SW | Ask sizes, slot k at bits k*SW upward |

## Verification
The assertions take it for granted that `cfgInst` is held steady while updates flow and that an update is offered only while `updReady` is high. With those inputs, level ordering, zeroed tails, one-cycle strobes and the busy window hold as invariants. The stimulus changes `cfgInst` only during reset, waits out each two-cycle busy window before offering the next update, and keeps every price nonzero and distinct within a side's intended content, so that the zero padding of unused slots can never be confused with a real level.

// File: rtl/bookPkg.sv
package bookPkg;

  typedef enum logic [1:0] {
    ACT_ADD = 2'd0,
    ACT_SET = 2'd1,
    ACT_SUB = 2'd2,
    ACT_NOP = 2'd3
  } bookAct_t;

  typedef struct packed {
    logic capture;
    logic apply;
  } bookStrobe_t;

endpackage

// File: rtl/bookSide.sv
module bookSide #(
  parameter int PW     = 32,
  parameter int SW     = 32,
  parameter int DEPTH  = 20,
  parameter int TOP    = 16,
  parameter bit IS_BID = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              applyEn,
  input  logic [1:0]        act,
  input  logic [PW-1:0]     price,
  input  logic [SW-1:0]     size,
  output logic [TOP*PW-1:0] topPrice,
  output logic [TOP*SW-1:0] topSize,
  output logic              topChanged
);
  import bookPkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] lvlPrice [DEPTH];
  logic [SW-1:0] lvlSize  [DEPTH];
  logic [CW-1:0] lvlCnt;

  logic [PW-1:0] nxtPrice [DEPTH];
  logic [SW-1:0] nxtSize  [DEPTH];
  logic [CW-1:0] nxtCnt;

  logic [CW-1:0] posIdx;
  logic          found;
  logic [SW-1:0] hitSize;
  logic          doIns, doRem, doSet;
  logic [SW-1:0] setVal;
  logic          diff;

  // Position search: number of held levels strictly better than the price.
  always_comb begin
    posIdx  = '0;
    found   = 1'b0;
    hitSize = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < lvlCnt) begin
        if (IS_BID ? (lvlPrice[i] > price) : (lvlPrice[i] < price))
          posIdx = posIdx + CW'(1);
        if (lvlPrice[i] == price) begin
          found   = 1'b1;
          hitSize = lvlSize[i];
        end
      end
    end
  end

  // Action decode.
  always_comb begin
    doIns  = 1'b0;
    doRem  = 1'b0;
    doSet  = 1'b0;
    setVal = size;
    case (bookAct_t'(act))
      ACT_ADD: begin
        if (found) begin
          doSet  = 1'b1;
          setVal = hitSize + size;
        end else if (size != '0) begin
          doIns = 1'b1;
        end
      end
      ACT_SET: begin
        if (found) begin
          if (size == '0) doRem = 1'b1;
          else            doSet = 1'b1;
        end else if (size != '0) begin
          doIns = 1'b1;
        end
      end
      ACT_SUB: begin
        if (found) begin
          if (hitSize <= size) begin
            doRem = 1'b1;
          end else begin
            doSet  = 1'b1;
            setVal = hitSize - size;
          end
        end
      end
      default: ;
    endcase
  end

  // Next array: in-place set, shift-up removal or shift-down insertion.
  always_comb begin
    nxtCnt = lvlCnt;
    for (int i = 0; i < DEPTH; i++) begin
      nxtPrice[i] = lvlPrice[i];
      nxtSize[i]  = lvlSize[i];
      if (doSet && CW'(i) == posIdx) begin
        nxtSize[i] = setVal;
      end
      if (doRem && CW'(i) >= posIdx) begin
        nxtPrice[i] = (i == DEPTH-1) ? '0 : lvlPrice[(i == DEPTH-1) ? i : i+1];
        nxtSize[i]  = (i == DEPTH-1) ? '0 : lvlSize[(i == DEPTH-1) ? i : i+1];
      end
      if (doIns && CW'(i) == posIdx) begin
        nxtPrice[i] = price;
        nxtSize[i]  = size;
      end else if (doIns && CW'(i) > posIdx) begin
        nxtPrice[i] = lvlPrice[(i == 0) ? 0 : i-1];
        nxtSize[i]  = lvlSize[(i == 0) ? 0 : i-1];
      end
    end
    if (doRem) nxtCnt = lvlCnt - CW'(1);
    if (doIns && posIdx < CW'(DEPTH) && lvlCnt < CW'(DEPTH)) nxtCnt = lvlCnt + CW'(1);
  end

  // Visible-top comparison.
  always_comb begin
    diff = 1'b0;
    for (int t = 0; t < TOP; t++) begin
      if (nxtPrice[t] != lvlPrice[t] || nxtSize[t] != lvlSize[t]) diff = 1'b1;
    end
  end
  assign topChanged = applyEn && diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvlCnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        lvlPrice[i] <= '0;
        lvlSize[i]  <= '0;
      end
    end else if (applyEn) begin
      lvlCnt <= nxtCnt;
      for (int i = 0; i < DEPTH; i++) begin
        lvlPrice[i] <= nxtPrice[i];
        lvlSize[i]  <= nxtSize[i];
      end
    end
  end

  for (genvar t = 0; t < TOP; t++) begin : gTop
    assign topPrice[t*PW +: PW] = lvlPrice[t];
    assign topSize[t*SW +: SW]  = lvlSize[t];
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) lvlCnt <= CW'(DEPTH)); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !applyEn |=> $stable(lvlCnt)); // R8

  for (genvar i = 0; i < DEPTH - 1; i++) begin : gOrder
    AST_LEVEL_ORDER: assert property (@(posedge clk) disable iff (rst)
      (CW'(i + 1) < lvlCnt) |-> (IS_BID ? (lvlPrice[i] > lvlPrice[i+1]) : (lvlPrice[i] < lvlPrice[i+1]))); // R2
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gTail
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
      (CW'(i) >= lvlCnt) |-> (lvlPrice[i] == '0 && lvlSize[i] == '0)); // R10
  end

endmodule

// File: rtl/bookCtrl.sv
module bookCtrl (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 updValid,
  input  logic                 instMatch,
  input  logic                 changed,
  output logic                 updReady,
  output logic                 snapValid,
  output bookPkg::bookStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_APPLY, ST_EMIT} ctrlState_t;
  ctrlState_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (updValid && instMatch) state <= ST_APPLY;
        ST_APPLY: state <= ST_EMIT;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign updReady       = (state == ST_IDLE);
  assign strobe.capture = (state == ST_IDLE) && updValid && instMatch;
  assign strobe.apply   = (state == ST_APPLY);
  assign snapValid      = (state == ST_EMIT) && changed;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst) snapValid |=> !snapValid); // R6
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (updValid && updReady && instMatch) |=> !updReady); // R9
  AST_FOREIGN_PASS: assert property (@(posedge clk) disable iff (rst)
    (updValid && updReady && !instMatch) |=> (updReady && !snapValid)); // R8

endmodule

// File: rtl/bookPath.sv
module bookPath #(
  parameter int PW    = 32,
  parameter int SW    = 32,
  parameter int TW    = 48,
  parameter int IW    = 16,
  parameter int DEPTH = 20,
  parameter int TOP   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  bookPkg::bookStrobe_t strobe,
  input  logic [IW-1:0]        cfgInst,
  input  logic [1:0]           updAction,
  input  logic                 updSide,
  input  logic [IW-1:0]        updInst,
  input  logic [PW-1:0]        updPrice,
  input  logic [SW-1:0]        updSize,
  input  logic [TW-1:0]        updTime,
  output logic                 instMatch,
  output logic                 changed,
  output logic [IW-1:0]        snapInst,
  output logic [TW-1:0]        snapTime,
  output logic [TOP*PW-1:0]    snapBidPrice,
  output logic [TOP*SW-1:0]    snapBidSize,
  output logic [TOP*PW-1:0]    snapAskPrice,
  output logic [TOP*SW-1:0]    snapAskSize
);
  logic [1:0]    uAct;
  logic          uSide;
  logic [PW-1:0] uPrice;
  logic [SW-1:0] uSize;
  logic [TW-1:0] uTime;
  logic [IW-1:0] uInst;
  logic          changedQ;

  logic [TOP*PW-1:0] sideP [2];
  logic [TOP*SW-1:0] sideS [2];
  logic [1:0]        sideChg;

  assign instMatch = (updInst == cfgInst);

  always_ff @(posedge clk) begin
    if (rst) begin
      uAct     <= '0;
      uSide    <= 1'b0;
      uPrice   <= '0;
      uSize    <= '0;
      uTime    <= '0;
      uInst    <= '0;
      changedQ <= 1'b0;
    end else begin
      if (strobe.capture) begin
        uAct   <= updAction;
        uSide  <= updSide;
        uPrice <= updPrice;
        uSize  <= updSize;
        uTime  <= updTime;
        uInst  <= updInst;
      end
      if (strobe.apply) changedQ <= |sideChg;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : gSide
    bookSide #(
      .PW(PW), .SW(SW), .DEPTH(DEPTH), .TOP(TOP), .IS_BID(s == 0)
    ) uSideBook (
      .clk       (clk),
      .rst       (rst),
      .applyEn   (strobe.apply && (uSide == 1'(s))),
      .act       (uAct),
      .price     (uPrice),
      .size      (uSize),
      .topPrice  (sideP[s]),
      .topSize   (sideS[s]),
      .topChanged(sideChg[s])
    );
  end

  assign changed      = changedQ;
  assign snapInst     = uInst;
  assign snapTime     = uTime;
  assign snapBidPrice = sideP[0];
  assign snapBidSize  = sideS[0];
  assign snapAskPrice = sideP[1];
  assign snapAskSize  = sideS[1];

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst) $countones(sideChg) <= 1); // R2

endmodule

// File: rtl/priceLevelBook.sv
module priceLevelBook #(
  parameter int PW    = 32,
  parameter int SW    = 32,
  parameter int TW    = 48,
  parameter int IW    = 16,
  parameter int DEPTH = 20,
  parameter int TOP   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     cfgInst,
  input  logic              updValid,
  output logic              updReady,
  input  logic [1:0]        updAction,
  input  logic              updSide,
  input  logic [IW-1:0]     updInst,
  input  logic [PW-1:0]     updPrice,
  input  logic [SW-1:0]     updSize,
  input  logic [TW-1:0]     updTime,
  output logic              snapValid,
  output logic [IW-1:0]     snapInst,
  output logic [TW-1:0]     snapTime,
  output logic [TOP*PW-1:0] snapBidPrice,
  output logic [TOP*SW-1:0] snapBidSize,
  output logic [TOP*PW-1:0] snapAskPrice,
  output logic [TOP*SW-1:0] snapAskSize
);
  bookPkg::bookStrobe_t strobe;
  logic instMatch;
  logic changed;

  bookCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .updValid (updValid),
    .instMatch(instMatch),
    .changed  (changed),
    .updReady (updReady),
    .snapValid(snapValid),
    .strobe   (strobe)
  );

  bookPath #(
    .PW(PW), .SW(SW), .TW(TW), .IW(IW), .DEPTH(DEPTH), .TOP(TOP)
  ) uPath (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .cfgInst     (cfgInst),
    .updAction   (updAction),
    .updSide     (updSide),
    .updInst     (updInst),
    .updPrice    (updPrice),
    .updSize     (updSize),
    .updTime     (updTime),
    .instMatch   (instMatch),
    .changed     (changed),
    .snapInst    (snapInst),
    .snapTime    (snapTime),
    .snapBidPrice(snapBidPrice),
    .snapBidSize (snapBidSize),
    .snapAskPrice(snapAskPrice),
    .snapAskSize (snapAskSize)
  );

endmodule

// File: tb/sim_priceLevelBook.sv
`timescale 1ns/1ps
module sim_priceLevelBook;
  localparam int PW = 32, SW = 32, TW = 48, IW = 16, DEPTH = 20, TOP = 16;
  localparam int INST = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] cfgInst = IW'(INST);
  logic updValid = 1'b0;
  logic updReady;
  logic [1:0] updAction = '0;
  logic updSide = 1'b0;
  logic [IW-1:0] updInst = '0;
  logic [PW-1:0] updPrice = '0;
  logic [SW-1:0] updSize = '0;
  logic [TW-1:0] updTime = '0;
  logic snapValid;
  logic [IW-1:0] snapInst;
  logic [TW-1:0] snapTime;
  logic [TOP*PW-1:0] snapBidPrice, snapAskPrice;
  logic [TOP*SW-1:0] snapBidSize, snapAskSize;

  int nChecks = 0;
  int nErrors = 0;
  bit lastPulse;

  always #5 clk = ~clk;

  priceLevelBook #(.PW(PW), .SW(SW), .TW(TW), .IW(IW), .DEPTH(DEPTH), .TOP(TOP)) u0 (
    .clk(clk), .rst(rst), .cfgInst(cfgInst), .updValid(updValid), .updReady(updReady),
    .updAction(updAction), .updSide(updSide), .updInst(updInst), .updPrice(updPrice),
    .updSize(updSize), .updTime(updTime), .snapValid(snapValid), .snapInst(snapInst),
    .snapTime(snapTime), .snapBidPrice(snapBidPrice), .snapBidSize(snapBidSize),
    .snapAskPrice(snapAskPrice), .snapAskSize(snapAskSize)
  );

  typedef struct packed {
    int act; int side; int price; int size; int pulse;
    int bidP; int bidS; int askP; int askS;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{0, 0, 100, 5, 1, 100, 5,   0, 0},
    '{0, 1, 105, 3, 1, 100, 5, 105, 3},
    '{0, 0, 101, 2, 1, 101, 2, 105, 3},
    '{0, 0,  99, 4, 1, 101, 2, 105, 3},
    '{0, 0, 101, 3, 1, 101, 5, 105, 3},
    '{0, 1, 104, 1, 1, 101, 5, 104, 1},
    '{1, 1, 104, 6, 1, 101, 5, 104, 6},
    '{1, 1, 104, 6, 0, 101, 5, 104, 6},
    '{2, 0, 101, 2, 1, 101, 3, 104, 6},
    '{2, 0,  98, 1, 0, 101, 3, 104, 6},
    '{2, 0, 101, 7, 1, 100, 5, 104, 6},
    '{1, 1, 104, 0, 1, 100, 5, 105, 3},
    '{3, 0, 100, 9, 0, 100, 5, 105, 3},
    '{1, 0, 102, 8, 1, 102, 8, 105, 3},
    '{0, 0,  97, 0, 0, 102, 8, 105, 3}
  };

  function automatic int bidP(int k); return int'(snapBidPrice[k*PW +: PW]); endfunction
  function automatic int bidS(int k); return int'(snapBidSize[k*SW +: SW]); endfunction
  function automatic int askP(int k); return int'(snapAskPrice[k*PW +: PW]); endfunction
  function automatic int askS(int k); return int'(snapAskSize[k*SW +: SW]); endfunction

  task automatic chk(input string tag, input longint actual, input longint expected);
    nChecks++;
    if (actual != expected) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  // Offers one update while idle and observes the busy window and the strobe.
  task automatic sendUpd(input int act, input int side, input int inst, input int price,
                         input int size, input int tstamp);
    bit r1, r2, s0, s2;
    @(negedge clk);
    updValid  = 1'b1;
    updAction = 2'(act);
    updSide   = 1'(side);
    updInst   = IW'(inst);
    updPrice  = PW'(price);
    updSize   = SW'(size);
    updTime   = TW'(tstamp);
    @(posedge clk);
    #1 updValid = 1'b0;
    @(negedge clk);
    r1 = updReady; s0 = snapValid;
    @(negedge clk);
    lastPulse = snapValid; r2 = updReady;
    @(negedge clk);
    s2 = snapValid;
    if (inst == INST) begin
      chk("R9 ready low first busy cycle", longint'(r1), 0);
      chk("R9 ready low second busy cycle", longint'(r2), 0);
      chk("R6 no strobe outside emit cycle", longint'(s0 | s2), 0);
    end else begin
      chk("R8 ready stays high on foreign update", longint'(r1), 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    bit allZero;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", longint'(updReady), 1);
    chk("R1 no strobe after reset", longint'(snapValid), 0);
    allZero = 1'b1;
    for (int k = 0; k < TOP; k++)
      if (bidP(k) != 0 || bidS(k) != 0 || askP(k) != 0 || askS(k) != 0) allZero = 1'b0;
    chk("R1 all slots zero", longint'(allZero), 1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      case (VECS[i].act)
        0: tag = "R3 add";
        1: tag = "R4 set";
        2: tag = "R5 subtract";
        default: tag = "R11 no-op code";
      endcase
      sendUpd(VECS[i].act, VECS[i].side, INST, VECS[i].price, VECS[i].size, 1000 + i);
      chk({tag, " R6 strobe"}, longint'(lastPulse), VECS[i].pulse);
      chk({tag, " R2 best bid price"}, bidP(0), VECS[i].bidP);
      chk({tag, " best bid size"}, bidS(0), VECS[i].bidS);
      chk({tag, " R2 best ask price"}, askP(0), VECS[i].askP);
      chk({tag, " best ask size"}, askS(0), VECS[i].askS);
      if (VECS[i].pulse != 0) begin
        chk("R7 snapshot timestamp", longint'(snapTime), 1000 + i);
        chk("R7 snapshot instrument", longint'(snapInst), INST);
      end
    end
    // Deeper slots: bids 102/8, 100/5, 99/4; asks 105/3
    chk("R2 bid slot1 price", bidP(1), 100);
    chk("R2 bid slot2 price", bidP(2), 99);
    chk("R2 bid slot2 size", bidS(2), 4);
    chk("R10 bid slot3 empty", bidP(3) + bidS(3), 0);
    chk("R10 ask slot1 empty", askP(1) + askS(1), 0);

    // R8 foreign instrument
    sendUpd(0, 0, 9, 200, 1, 2000);
    chk("R8 no strobe on foreign update", longint'(lastPulse), 0);
    sendUpd(2, 0, INST, 99, 1, 2001);
    chk("R8 strobe after follow-up", longint'(lastPulse), 1);
    chk("R8 foreign price absent from top", bidP(0), 102);
    chk("R8 slot2 size after subtract", bidS(2), 3);

    // R10 depth handling on a fresh book
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    for (int p = 100; p <= 116; p++) begin
      sendUpd(0, 0, INST, p, 1, p);
      chk("R2 new best bid strobes", longint'(lastPulse), 1);
    end
    sendUpd(0, 0, INST, 100, 5, 3000);
    chk("R6 change below visible top gives no strobe", longint'(lastPulse), 0);
    for (int p = 117; p <= 119; p++) sendUpd(0, 0, INST, p, 1, p);
    chk("R10 book top at fill", bidP(0), 119);
    sendUpd(0, 0, INST, 90, 1, 3001);
    chk("R10 worse price on full side gives no strobe", longint'(lastPulse), 0);
    sendUpd(0, 0, INST, 130, 1, 3002);
    chk("R10 better price on full side strobes", longint'(lastPulse), 1);
    chk("R10 better price at slot0", bidP(0), 130);
    sendUpd(2, 0, INST, 130, 1, 3003);
    for (int p = 119; p >= 113; p--) sendUpd(2, 0, INST, p, 1, p);
    chk("R5 removal strobe", longint'(lastPulse), 1);
    chk("R10 slot0 after removals", bidP(0), 112);
    chk("R10 slot11 holds last kept level", bidP(11), 101);
    chk("R10 slot12 empty after push-out and drop", bidP(12) + bidS(12), 0);

    summary();
  end
endmodule